// File: doc/BRIEF.md
# Dual-Lane Falling Marker Tracker

This block keeps the positions of note markers that fall down two side-by-side lanes of a 32-row rhythm-game screen. Each lane is an occupancy vector with one bit per row. Bit 0 is the top row and bit 31 is the bottom row. A start request places a marker in the top row of its own lane. An external controller sets the scroll rate with a slow beat signal: every rising edge of that signal moves every marker in both lanes down by one row.

Both lane vectors leave the block as registered outputs, so downstream drawing logic can turn them into an on/off frame. When a marker drops past the bottom row, the block raises a one-cycle exit pulse for that lane. A synchronous clear input empties both lanes, for example at the end of a round.

Top module: `beat_lane_tracker`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is applied, both lane vectors are all zeros and both exit outputs are low.
- R2: A scroll tick happens only in a cycle where `beat_in` is sampled high after being sampled low on the previous edge. A beat held high for several cycles gives exactly one shift. The shifted vectors appear at the same clock edge that samples the rising beat.
- R3: When `start_left` is high at a clock edge, bit 0 of `lane_left` is 1 after that edge. `start_right` does the same for `lane_right`.
- R4: On a tick, bit i of each lane moves to bit i+1 in both lanes. Bit 0 becomes 0 unless a start request for that lane is present in the same cycle.
- R5: When a start request and a tick fall in the same cycle, the shift is applied first and bit 0 is then set. The new marker is not lost.
- R6: If bit 31 of a lane is set when a tick occurs, that marker is discarded. The lane's exit output is high for exactly the one cycle in which the shifted vector appears.
- R7: Without a tick, lane contents hold. Only a start request can change them, and it can only set bit 0.
- R8: When `clear` is high at an edge, both lanes become all zeros and both exit outputs are low after that edge. This holds even if a tick or start requests occur in the same cycle.
- R9: The lanes are independent: a start request for one lane never changes the other lane's vector or exit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_in | input | 1 | Beat-rate level from the game controller; its rising edge scrolls the lanes |
| start_left | input | 1 | Place a marker at the top of the left lane |
| start_right | input | 1 | Place a marker at the top of the right lane |
| clear | input | 1 | Synchronous empty of both lanes |
| lane_left | output | ROWS | Left lane occupancy, bit 0 = top row |
| lane_right | output | ROWS | Right lane occupancy, bit 0 = top row |
| exit_left | output | 1 | One-cycle pulse when a left marker leaves the bottom |
| exit_right | output | 1 | One-cycle pulse when a right marker leaves the bottom |

## Verification
The bench holds the beat signal high for several cycles. A design that shifted on level instead of on the edge would move markers several rows per beat.

It places a start request in the same cycle as a beat edge. A design that set bit 0 before shifting would push the new marker straight to row 1 and leave the top row empty.

It walks a marker down to the bottom row and then past it. A design with an off-by-one exit would pulse too early, keep the marker, or hold the pulse for more than one cycle.

It applies clear together with a beat edge and both starts. A design that gave clear the wrong priority would leave a marker in row 0 behind.

// File: rtl/beat_pkg.sv
package beat_pkg;
  localparam int NUM_LANES = 2;
  typedef enum logic [0:0] {
    LANE_LEFT  = 1'b0,
    LANE_RIGHT = 1'b1
  } lane_sel_e;
endpackage

// File: rtl/beat_edge_pulse.sv
module beat_edge_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_in;
  end

  assign pulse_o = level_in & ~prev_q;

  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/marker_lane.sv
module marker_lane #(
  parameter int ROWS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            inject,
  input  logic            clr,
  output logic [ROWS-1:0] occ,
  output logic            exit_o
);
  localparam int LAST = ROWS - 1;

  logic [ROWS-1:0] occ_nxt;

  always_comb begin
    occ_nxt = occ;
    if (tick)   occ_nxt = {occ[LAST-1:0], 1'b0};
    if (inject) occ_nxt[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      occ    <= '0;
      exit_o <= 1'b0;
    end else begin
      occ    <= occ_nxt;
      exit_o <= tick & occ[LAST];
    end
  end

  // R4
  shift_down_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr) |=> occ[LAST:1] == $past(occ[LAST-1:0]));

  // R3
  inject_top_chk: assert property (@(posedge clk) disable iff (rst)
    (inject && !clr) |=> occ[0]);

  // R6
  exit_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && occ[LAST]) |=> exit_o);

  // R6
  exit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !exit_o);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !inject && !clr) |=> $stable(occ));

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (occ == '0) && !exit_o);
endmodule

// File: rtl/beat_lane_tracker.sv
module beat_lane_tracker
  import beat_pkg::*;
#(
  parameter int ROWS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            beat_in,
  input  logic            start_left,
  input  logic            start_right,
  input  logic            clear,
  output logic [ROWS-1:0] lane_left,
  output logic [ROWS-1:0] lane_right,
  output logic            exit_left,
  output logic            exit_right
);
  logic                 scroll_tick;
  logic [NUM_LANES-1:0] start_vec;
  logic [NUM_LANES-1:0] exit_vec;
  logic [ROWS-1:0]      occ_vec [NUM_LANES];

  beat_edge_pulse u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (beat_in),
    .pulse_o  (scroll_tick)
  );

  assign start_vec[LANE_LEFT]  = start_left;
  assign start_vec[LANE_RIGHT] = start_right;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    marker_lane #(.ROWS(ROWS)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .tick   (scroll_tick),
      .inject (start_vec[g]),
      .clr    (clear),
      .occ    (occ_vec[g]),
      .exit_o (exit_vec[g])
    );
  end

  assign lane_left  = occ_vec[LANE_LEFT];
  assign lane_right = occ_vec[LANE_RIGHT];
  assign exit_left  = exit_vec[LANE_LEFT];
  assign exit_right = exit_vec[LANE_RIGHT];

  // R9
  right_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (!scroll_tick && !clear && !start_right) |=> $stable(lane_right));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (lane_left == '0) && (lane_right == '0) && !exit_left && !exit_right);
endmodule

// File: tb/tb_beat_lane_tracker.sv
module tb_beat_lane_tracker;
  localparam int ROWS = 32;

  logic clk = 1'b0;
  logic rst, beat_in, start_left, start_right, clear;
  logic [ROWS-1:0] lane_left, lane_right;
  logic exit_left, exit_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [ROWS-1:0] exp_l, exp_r;
  logic exp_xl, exp_xr, prev_beat;

  always #10 clk = ~clk;

  beat_lane_tracker #(.ROWS(ROWS)) dut (
    .clk(clk), .rst(rst), .beat_in(beat_in),
    .start_left(start_left), .start_right(start_right), .clear(clear),
    .lane_left(lane_left), .lane_right(lane_right),
    .exit_left(exit_left), .exit_right(exit_right)
  );

  task automatic compare(input string tag);
    checks++;
    if (lane_left !== exp_l || lane_right !== exp_r ||
        exit_left !== exp_xl || exit_right !== exp_xr) begin
      errors++;
      $display("FAIL %s: got L=%h R=%h xl=%b xr=%b expected L=%h R=%h xl=%b xr=%b",
               tag, lane_left, lane_right, exit_left, exit_right,
               exp_l, exp_r, exp_xl, exp_xr);
    end
  endtask

  // One clock: drive at negedge, model the edge, sample 1 ns after posedge.
  task automatic step(input logic b, input logic sl, input logic sr,
                      input logic cl, input string tag);
    logic tick;
    @(negedge clk);
    beat_in = b; start_left = sl; start_right = sr; clear = cl;
    @(posedge clk);
    tick = b & ~prev_beat;
    prev_beat = b;
    if (cl) begin
      exp_l = '0; exp_r = '0; exp_xl = 1'b0; exp_xr = 1'b0;
    end else begin
      exp_xl = tick & exp_l[ROWS-1];
      exp_xr = tick & exp_r[ROWS-1];
      if (tick) begin
        exp_l = exp_l << 1;
        exp_r = exp_r << 1;
      end
      if (sl) exp_l[0] = 1'b1;
      if (sr) exp_r[0] = 1'b1;
    end
    #1;
    compare(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; beat_in = 1'b0; start_left = 1'b1; start_right = 1'b1; clear = 1'b0;
    @(posedge clk); #1;
    exp_l = '0; exp_r = '0; exp_xl = 1'b0; exp_xr = 1'b0; prev_beat = 1'b0;
    compare("R1 reset");
    @(negedge clk);
    start_left = 1'b0; start_right = 1'b0;
    @(posedge clk); #1;
    compare("R1 reset held");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_inject();
    step(0, 1, 0, 0, "R3 inject left");
    step(0, 0, 0, 0, "R9 right untouched");
    step(0, 0, 1, 0, "R3 inject right");
    step(0, 0, 0, 0, "R7 idle hold");
  endtask

  task automatic t_shift();
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0, "R4 shift on beat edge");
      step(0, 0, 0, 0, "R7 hold between beats");
    end
  endtask

  task automatic t_held_beat();
    step(1, 0, 0, 0, "R2 rising beat shifts");
    step(1, 0, 0, 0, "R2 held beat no shift");
    step(1, 0, 0, 0, "R2 held beat no shift");
    step(0, 0, 0, 0, "R2 beat low");
  endtask

  task automatic t_coincide();
    step(1, 1, 1, 0, "R5 start with tick");
    step(0, 0, 0, 0, "R5 settle");
    step(0, 1, 0, 0, "R7 start sets only bit 0");
  endtask

  task automatic t_exit();
    step(0, 0, 0, 1, "R8 clear before exit");
    step(0, 1, 0, 0, "R6 seed left");
    for (int i = 0; i < ROWS - 1; i++) begin
      step(1, 0, 0, 0, "R4 walk down");
      step(0, 0, 0, 0, "R6 no early exit");
    end
    step(1, 0, 0, 0, "R6 exit pulse");
    step(0, 0, 0, 0, "R6 exit one cycle");
  endtask

  task automatic t_clear();
    step(0, 1, 1, 0, "R3 seed both");
    step(1, 0, 0, 0, "R4 move both");
    step(0, 0, 0, 0, "R7 hold");
    step(1, 1, 1, 1, "R8 clear wins over tick and start");
    step(0, 0, 0, 0, "R8 stays empty");
  endtask

  task automatic t_pattern();
    for (int i = 0; i < 12; i++) begin
      step(1'(i % 2), 1'(i % 3 == 0), 1'(i % 5 == 1), 0, "R9 mixed pattern");
    end
  endtask

  initial begin
    t_reset();
    t_inject();
    t_shift();
    t_held_beat();
    t_coincide();
    t_exit();
    t_clear();
    t_pattern();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule